// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Starvation Escalation

This block shares a set of independent target buses between two masters: a main processor and a debug controller. Each master presents a request, a target index and an end-of-operation flag. For every target the block decides which master is connected and raises a stall for any master whose request is not served. Each target has its own arbitration slice, so masters that address different targets proceed in parallel.

On a conflict the processor normally wins. Each slice counts the consecutive cycles in which the debug master has been refused. Once that count reaches the starvation limit (128), the debug master wins the next free arbitration for that target. No master is ever cut off in the middle of a transfer. A slice stays locked to its owner until that owner flags the last cycle of its operation. After an escalated debug access completes, priority returns to the processor. The block raises no interrupts.

Top module: `busarb_top`

## Requirements
- R1: In every cycle, at most one of `main_gnt[t]` and `dbg_gnt[t]` is high for each target t.
- R2: A master's target index t selects bit t of its grant vector. Two masters requesting different free targets are both granted in the same cycle, and neither is stalled.
- R3: When both masters request the same free target and the debug master is not escalated, the main master is granted. `dbg_stall` is 1 and `dbg_gnt` is 0.
- R4: Take a target that the debug master has requested and been denied in each of the 128 (the starvation limit) cycles just before. If that target is free and both masters request it, the debug master is granted and `main_stall` is 1. After only 127 denied cycles, the main master still wins.
- R5: A master granted with its last flag low keeps the grant in the following cycle while it keeps requesting. The other master is not granted that target until after the owner's cycle with the last flag high.
- R6: The starvation count clears whenever the debug master does not request the target or is granted it. The count saturates rather than wrapping: after 300 or more denied cycles, the debug master still wins the next free arbitration.
- R7: After an escalated debug access completes, the next conflict on that target is won by the main master.
- R8: A master's stall is high exactly when it requests and holds no grant. During an escalated debug transfer, `main_stall` stays high, and it falls in the cycle after the debug master's last cycle.
- R9: While `rst` is high, all grants and stalls are 0. After reset, the starvation count is zero, so the first conflict goes to the main master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| main_req | input | 1 | Main master requests a target |
| main_tgt | input | TGT_W | Main master target index |
| main_last | input | 1 | Main master's current cycle ends its operation |
| dbg_req | input | 1 | Debug master requests a target |
| dbg_tgt | input | TGT_W | Debug master target index |
| dbg_last | input | 1 | Debug master's current cycle ends its operation |
| main_gnt | output | NUM_TGT | Per-target grant to the main master |
| dbg_gnt | output | NUM_TGT | Per-target grant to the debug master |
| main_stall | output | 1 | Main master is requesting but not granted |
| dbg_stall | output | 1 | Debug master is requesting but not granted |

## Verification
Escalation and operation locking can both affect the same cycle. The main master may hold a long operation while the debug count reaches and passes the limit. The bench provokes this with a 300-cycle main transfer that covers both the threshold and the saturation point. It then checks that the debug master wins only in the first free cycle after the main master's last flag, and never before. A second test runs back-to-back single-cycle main operations. These make the exact 128th-cycle crossover and the count clearing on withdrawal visible as grant flips at the ports.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_MAIN = 2'd1,
    OWN_DBG  = 2'd2
  } owner_e;

  // Starvation count step: clear when idle or served, else saturating increment.
  function automatic int unsigned starve_step(input int unsigned cnt,
                                              input logic pending,
                                              input logic served,
                                              input int unsigned limit);
    if (!pending || served) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // Escalation test kept as a function so a bench can restate it independently.
  function automatic logic is_escalated(input int unsigned cnt,
                                        input int unsigned limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/arb_req_decode.sv
module arb_req_decode #(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 2
) (
  input  logic               req,
  input  logic [TGT_W-1:0]   tgt,
  output logic [NUM_TGT-1:0] req_vec
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_dec
    assign req_vec[t] = req && (tgt == TGT_W'(t));
  end
endmodule

// File: rtl/arb_starve_ctr.sv
module arb_starve_ctr
  import busarb_pkg::*;
#(
  parameter int STARVE_LIMIT = 128,
  localparam int CNT_W = $clog2(STARVE_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             served,
  output logic             escalated,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(starve_step(int'(cnt_q), pending, served, STARVE_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign escalated = is_escalated(int'(cnt_q), STARVE_LIMIT);

  // R6: the count never exceeds the limit and holds once saturated
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(STARVE_LIMIT));
  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(STARVE_LIMIT) && pending && !served) |=> (cnt_q == CNT_W'(STARVE_LIMIT)));
  // R6: withdrawal clears the count
  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !pending |=> (cnt_q == '0));
  // R9: reset leaves the count at zero
  assert_cnt_reset_R9: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/arb_target_slice.sv
module arb_target_slice
  import busarb_pkg::*;
#(
  parameter int STARVE_LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic main_rq,
  input  logic main_last,
  input  logic dbg_rq,
  input  logic dbg_last,
  output logic main_g,
  output logic dbg_g
);
  localparam int CNT_W = $clog2(STARVE_LIMIT + 1);

  owner_e owner_q, owner_d;
  logic   conflict_w;
  logic   escalate_w;
  logic   target_free_w;
  logic [CNT_W-1:0] starve_cnt;

  assign conflict_w    = main_rq && dbg_rq;
  assign target_free_w = (owner_q == OWN_FREE);

  arb_starve_ctr #(.STARVE_LIMIT(STARVE_LIMIT)) i_ctr (
    .clk       (clk),
    .rst       (rst),
    .pending   (dbg_rq),
    .served    (dbg_g),
    .escalated (escalate_w),
    .cnt_q     (starve_cnt)
  );

  always_comb begin
    main_g = 1'b0;
    dbg_g  = 1'b0;
    unique case (owner_q)
      OWN_MAIN: main_g = main_rq;
      OWN_DBG:  dbg_g  = dbg_rq;
      default: begin
        if (conflict_w) begin
          if (escalate_w) dbg_g  = 1'b1;
          else            main_g = 1'b1;
        end else begin
          main_g = main_rq;
          dbg_g  = dbg_rq;
        end
      end
    endcase
    if (rst) begin
      main_g = 1'b0;
      dbg_g  = 1'b0;
    end
  end

  always_comb begin
    if (main_g && !main_last)     owner_d = OWN_MAIN;
    else if (dbg_g && !dbg_last)  owner_d = OWN_DBG;
    else                          owner_d = OWN_FREE;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_FREE;
    else     owner_q <= owner_d;
  end

  assert_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(main_g && dbg_g));
  assert_main_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (target_free_w && conflict_w && !escalate_w) |-> main_g);
  assert_escalate_R4: assert property (@(posedge clk) disable iff (rst)
    (target_free_w && conflict_w && escalate_w) |-> dbg_g);
  assert_hold_main_R5: assert property (@(posedge clk) disable iff (rst)
    (main_g && !main_last) |=> (!main_rq || (main_g && !dbg_g)));
  assert_hold_dbg_R5: assert property (@(posedge clk) disable iff (rst)
    (dbg_g && !dbg_last) |=> (!dbg_rq || (dbg_g && !main_g)));
endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int NUM_TGT      = 4,
  parameter int STARVE_LIMIT = 128,
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               main_req,
  input  logic [TGT_W-1:0]   main_tgt,
  input  logic               main_last,
  input  logic               dbg_req,
  input  logic [TGT_W-1:0]   dbg_tgt,
  input  logic               dbg_last,
  output logic [NUM_TGT-1:0] main_gnt,
  output logic [NUM_TGT-1:0] dbg_gnt,
  output logic               main_stall,
  output logic               dbg_stall
);
  logic [NUM_TGT-1:0] main_rq_vec;
  logic [NUM_TGT-1:0] dbg_rq_vec;

  arb_req_decode #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) i_dec_main (
    .req(main_req), .tgt(main_tgt), .req_vec(main_rq_vec));
  arb_req_decode #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) i_dec_dbg (
    .req(dbg_req), .tgt(dbg_tgt), .req_vec(dbg_rq_vec));

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_slice
    arb_target_slice #(.STARVE_LIMIT(STARVE_LIMIT)) i_slice (
      .clk       (clk),
      .rst       (rst),
      .main_rq   (main_rq_vec[t]),
      .main_last (main_last),
      .dbg_rq    (dbg_rq_vec[t]),
      .dbg_last  (dbg_last),
      .main_g    (main_gnt[t]),
      .dbg_g     (dbg_gnt[t])
    );
  end

  assign main_stall = !rst && main_req && !(|main_gnt);
  assign dbg_stall  = !rst && dbg_req  && !(|dbg_gnt);

  // R2: a master is granted at most the one target it addresses
  assert_one_tgt_main_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(main_gnt));
  assert_one_tgt_dbg_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dbg_gnt));
  // R9: nothing granted or stalled while reset is held
  always_comb begin
    if (rst) assert_reset_quiet_R9: assert (main_gnt == '0 && dbg_gnt == '0 && !main_stall && !dbg_stall);
  end
endmodule

// File: tb/test_busarb_top.sv
`timescale 1ns/1ps
module test_busarb_top;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_req = 1'b0, main_last = 1'b0, dbg_req = 1'b0, dbg_last = 1'b0;
  logic [1:0] main_tgt = '0, dbg_tgt = '0;
  logic [NT-1:0] main_gnt, dbg_gnt;
  logic main_stall, dbg_stall;

  always #2.5 clk = ~clk;

  busarb_top #(.NUM_TGT(NT), .STARVE_LIMIT(128)) i_busarb_top (
    .clk(clk), .rst(rst),
    .main_req(main_req), .main_tgt(main_tgt), .main_last(main_last),
    .dbg_req(dbg_req), .dbg_tgt(dbg_tgt), .dbg_last(dbg_last),
    .main_gnt(main_gnt), .dbg_gnt(dbg_gnt),
    .main_stall(main_stall), .dbg_stall(dbg_stall));

  typedef struct {
    logic [NT-1:0] mg;
    logic [NT-1:0] dg;
    logic ms;
    logic ds;
    string tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Driver: apply one cycle of stimulus and queue the expected outputs
  task automatic drive(input logic r,
                       input logic mr, input int mt, input logic ml,
                       input logic dr, input int dt, input logic dl,
                       input logic [NT-1:0] emg, input logic [NT-1:0] edg,
                       input logic ems, input logic eds, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    rst = r;
    main_req = mr; main_tgt = 2'(mt); main_last = ml;
    dbg_req = dr;  dbg_tgt = 2'(dt);  dbg_last = dl;
    e.mg = emg; e.dg = edg; e.ms = ems; e.ds = eds; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, 0,0,0, 0,0,0, 4'b0000, 4'b0000, 0, 0, tag);
  endtask

  // Monitor: compare at the falling edge, away from the driving edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (main_gnt !== e.mg || dbg_gnt !== e.dg || main_stall !== e.ms || dbg_stall !== e.ds) begin
        misses++;
        $display("FAIL %s: got mg=%b dg=%b ms=%b ds=%b, expected mg=%b dg=%b ms=%b ds=%b",
                 e.tag, main_gnt, dbg_gnt, main_stall, dbg_stall, e.mg, e.dg, e.ms, e.ds);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R9: reset with active requests: everything quiet
    drive(1, 1,1,1, 1,1,1, 4'b0000, 4'b0000, 0, 0, "R9 reset quiet");
    drive(1, 1,2,1, 1,3,1, 4'b0000, 4'b0000, 0, 0, "R9 reset quiet");
    // R9/R3: first conflict after reset goes to main
    drive(0, 1,1,1, 1,1,1, 4'b0010, 4'b0000, 0, 1, "R9 R3 main wins after reset");
    idle("idle");
    // R2: different targets in parallel
    drive(0, 1,0,1, 1,2,1, 4'b0001, 4'b0100, 0, 0, "R2 parallel targets");
    drive(0, 1,3,1, 1,1,1, 4'b1000, 4'b0010, 0, 0, "R2 parallel targets");
    idle("idle");
    // R5: main multi-cycle operation is not split
    drive(0, 1,1,0, 0,0,0, 4'b0010, 4'b0000, 0, 0, "R5 main starts");
    drive(0, 1,1,0, 1,1,1, 4'b0010, 4'b0000, 0, 1, "R5 main holds");
    drive(0, 1,1,1, 1,1,1, 4'b0010, 4'b0000, 0, 1, "R5 main last");
    drive(0, 0,0,0, 1,1,1, 4'b0000, 4'b0010, 0, 0, "R5 dbg after release");
    idle("idle");
    // R4: exact threshold with single-cycle main operations
    for (int i = 0; i < 128; i++)
      drive(0, 1,0,1, 1,0,1, 4'b0001, 4'b0000, 0, 1, "R4 below limit main wins");
    drive(0, 1,0,1, 1,0,1, 4'b0000, 4'b0001, 1, 0, "R4 escalated dbg wins");
    drive(0, 1,0,1, 1,0,1, 4'b0001, 4'b0000, 0, 1, "R7 priority returns to main");
    idle("idle");
    // R6: withdrawal clears the count
    for (int i = 0; i < 100; i++)
      drive(0, 1,2,1, 1,2,1, 4'b0100, 4'b0000, 0, 1, "R6 pre-withdraw");
    drive(0, 1,2,1, 0,2,1, 4'b0100, 4'b0000, 0, 0, "R6 withdraw");
    for (int i = 0; i < 128; i++)
      drive(0, 1,2,1, 1,2,1, 4'b0100, 4'b0000, 0, 1, "R6 count restarted");
    drive(0, 1,2,1, 1,2,1, 4'b0000, 4'b0100, 1, 0, "R6 R4 escalation after fresh 128");
    idle("idle");
    // R6 saturation + R5 no pre-emption: 300-cycle main transfer
    for (int i = 0; i < 300; i++)
      drive(0, 1,3,0, 1,3,1, 4'b1000, 4'b0000, 0, 1, "R5 R6 long main op");
    drive(0, 1,3,1, 1,3,1, 4'b1000, 4'b0000, 0, 1, "R5 main last cycle");
    drive(0, 1,3,0, 1,3,0, 4'b0000, 4'b1000, 1, 0, "R6 saturated dbg wins");
    drive(0, 1,3,0, 1,3,1, 4'b0000, 4'b1000, 1, 0, "R8 main stalled during dbg op");
    drive(0, 1,3,1, 1,3,1, 4'b1000, 4'b0000, 0, 1, "R8 R7 main resumes after dbg last");
    idle("R8 idle no stall");
    // R1: conflicts on every target, one winner each
    for (int t = 0; t < NT; t++)
      drive(0, 1,t,1, 1,t,1, 4'(1 << t), 4'b0000, 0, 1, "R1 single winner");
    idle("idle");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule